// File: doc/BRIEF.md
# Real-Time Clock Counter Chain

This block keeps the time of day from a 32.768 kHz clock. A prescaler turns the input clock into a 128 Hz step. That step drives four cascaded counters: a sub-second counter in 1/128 s units, then seconds, minutes and hours. A mode bit picks where the hour counter wraps, either 24 or 256 hours. When the whole chain wraps to zero, the block sets a midnight flag and raises an interrupt. The interrupt stays high until software acknowledges the flag.

Software reaches the counters, the mode bit and the flag through a small synchronous register port. There is one address bus. Writes are strobed and take effect at the next clock edge. Read data is registered.

The block has two resets. A power-on reset clears everything. A warm reset, such as a watchdog or an external reset, clears only the flag, the prescaler phase and the read register. The time of day and the hour mode survive it.

Top module: `rtc_chain`

## Requirements
- R1: The sub-second counter advances by one after every 256 clock cycles in which `rtc_en` is high. It wraps from 127 to 0, and that wrap increments the seconds counter in the same edge.
- R2: The seconds counter and the minutes counter each wrap from 59 to 0. Each wrap carries one step into the next counter up.
- R3: With control bit 0 (hour mode) at 1, the hour counter wraps from 23 to 0. With the bit at 0, it wraps from 255 to 0.
- R4: A wrap of the hour counter sets the midnight flag (control bit 1) and drives `irq_midnight` high from the next cycle.
- R5: A write to address 0 with bit 1 at 0 clears the midnight flag. A write with bit 1 at 1 leaves the flag unchanged.
- R6: Power-on reset clears all counters, the hour mode and the flag. Warm reset clears the flag, the prescaler phase and `rd_data`, but keeps all four counters and the hour mode.
- R7: While `rtc_en` is low, the prescaler and all counters hold their values.
- R8: A write to a counter takes priority over an increment of that counter in the same cycle.
- R9: When the hardware sets the midnight flag and software clears it in the same cycle, the flag ends up set.
- R10: The register map is as follows:
  - Address 0 is control, with bit 0 as hour mode and bit 1 as the midnight flag.
  - Address 1 is the sub-second counter.
  - Address 2 is seconds.
  - Address 3 is minutes.
  - Address 4 is hours.
  - Other addresses read 0.
  - `rd_data` shows the register at `addr` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz time-base clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset, synchronous, active high; the time of day is kept |
| rtc_en | input | 1 | Enables the prescaler and counting |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_midnight | output | 1 | Pending interrupt; follows the midnight flag |

## Verification
Two pairs of events can fall in the same cycle. In the first, a counter step meets a software write to that counter. In the second, the hardware setting of the midnight flag meets a software clear of it. The bench provokes each one by counting exactly 255 enabled cycles after a warm reset has zeroed the prescaler phase. It then presents the write on the 256th enabled cycle, which is the edge that steps the chain. It judges the outcome by reading back the written counter, expected to hold the written value, and the control register, expected to show the flag still set.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned STAGES = 4;

  typedef enum logic [2:0] {
    ADR_CTRL = 3'd0,
    ADR_SUB  = 3'd1,
    ADR_SEC  = 3'd2,
    ADR_MIN  = 3'd3,
    ADR_HOUR = 3'd4
  } rtc_addr_e;

  localparam int unsigned CTRL_MODE_BIT = 0;
  localparam int unsigned CTRL_FLAG_BIT = 1;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  output logic tick
);
  logic [DIV_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (clr)     phase_q <= '0;
    else if (en) phase_q <= phase_q + 1'b1;
  end

  // One-cycle step on the last phase of each enabled period
  assign tick = en && (&phase_q);
endmodule

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         por,
  input  logic         step,
  input  logic [W-1:0] last,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] val,
  output logic         at_last
);
  // Values written above the limit also wrap on their next step
  assign at_last = (val >= last);

  always_ff @(posedge clk) begin
    if (por)       val <= '0;
    else if (wr)   val <= wr_val;
    else if (step) val <= at_last ? '0 : val + 1'b1;
  end
endmodule

// File: rtl/rtc_ctrl_flag.sv
module rtc_ctrl_flag (
  input  logic clk,
  input  logic por,
  input  logic warm_rst,
  input  logic wr_ctrl,
  input  logic wr_mode,
  input  logic wr_flag,
  input  logic set_flag,
  output logic hour_mode,
  output logic flag
);
  // The hour mode is kept through a warm reset
  always_ff @(posedge clk) begin
    if (por)          hour_mode <= 1'b0;
    else if (wr_ctrl) hour_mode <= wr_mode;
  end

  // A hardware set wins over a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (por || warm_rst)          flag <= 1'b0;
    else if (set_flag)            flag <= 1'b1;
    else if (wr_ctrl && !wr_flag) flag <= 1'b0;
  end
endmodule

// File: rtl/rtc_chain.sv
module rtc_chain
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned CW        = 8,
  parameter int unsigned AW        = 3,
  parameter int unsigned SUB_LAST  = 127,
  parameter int unsigned SEC_LAST  = 59,
  parameter int unsigned MIN_LAST  = 59,
  parameter int unsigned H24_LAST  = 23,
  parameter int unsigned H256_LAST = 255
) (
  input  logic          clk,
  input  logic          por,
  input  logic          warm_rst,
  input  logic          rtc_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  output logic          irq_midnight
);
  localparam int unsigned NS = STAGES;

  logic                   tick;
  logic                   hour_mode;
  logic                   flag;
  logic                   chain_wrap;
  logic                   wr_ctrl;
  logic [NS-1:0]          stage_step;
  logic [NS-1:0]          stage_at_last;
  logic [NS-1:0]          stage_wr;
  logic [NS-1:0][CW-1:0]  stage_last;
  logic [NS-1:0][CW-1:0]  stage_val;

  rtc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .clr  (por || warm_rst),
    .en   (rtc_en),
    .tick (tick)
  );

  always_comb begin
    stage_last[0] = CW'(SUB_LAST);
    stage_last[1] = CW'(SEC_LAST);
    stage_last[2] = CW'(MIN_LAST);
    stage_last[3] = hour_mode ? CW'(H24_LAST) : CW'(H256_LAST);
  end

  // Each stage steps when the tick has carried through every lower stage
  always_comb begin
    logic carry;
    carry = tick && !warm_rst;
    for (int i = 0; i < NS; i++) begin
      stage_step[i] = carry;
      carry = carry && stage_at_last[i];
    end
    chain_wrap = carry;
  end

  for (genvar g = 0; g < NS; g++) begin : g_stage
    assign stage_wr[g] = wr_en && (addr == AW'(g + 1));

    rtc_wrap_counter #(.W(CW)) u_cnt (
      .clk     (clk),
      .por     (por),
      .step    (stage_step[g]),
      .last    (stage_last[g]),
      .wr      (stage_wr[g]),
      .wr_val  (wr_data),
      .val     (stage_val[g]),
      .at_last (stage_at_last[g])
    );
  end

  assign wr_ctrl = wr_en && (addr == AW'(ADR_CTRL));

  rtc_ctrl_flag u_ctrl (
    .clk       (clk),
    .por       (por),
    .warm_rst  (warm_rst),
    .wr_ctrl   (wr_ctrl),
    .wr_mode   (wr_data[CTRL_MODE_BIT]),
    .wr_flag   (wr_data[CTRL_FLAG_BIT]),
    .set_flag  (chain_wrap),
    .hour_mode (hour_mode),
    .flag      (flag)
  );

  always_ff @(posedge clk) begin
    if (por || warm_rst) begin
      rd_data <= '0;
    end else begin
      case (addr)
        AW'(ADR_CTRL): begin
          rd_data                <= '0;
          rd_data[CTRL_MODE_BIT] <= hour_mode;
          rd_data[CTRL_FLAG_BIT] <= flag;
        end
        AW'(ADR_SUB):  rd_data <= stage_val[0];
        AW'(ADR_SEC):  rd_data <= stage_val[1];
        AW'(ADR_MIN):  rd_data <= stage_val[2];
        AW'(ADR_HOUR): rd_data <= stage_val[3];
        default:       rd_data <= '0;
      endcase
    end
  end

  assign irq_midnight = flag;
endmodule

// File: rtl/rtc_chain_checker.sv
module rtc_chain_checker #(
  parameter int unsigned CW = 8,
  parameter int unsigned AW = 3
) (
  input logic            clk,
  input logic            por,
  input logic            warm_rst,
  input logic            rtc_en,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [CW-1:0]   wr_data,
  input logic            tick,
  input logic            hour_mode,
  input logic            irq,
  input logic [4*CW-1:0] vals
);
  logic [CW-1:0] sub_v, sec_v, min_v, hour_v;
  logic          low_full, full_now;

  assign sub_v    = vals[0*CW +: CW];
  assign sec_v    = vals[1*CW +: CW];
  assign min_v    = vals[2*CW +: CW];
  assign hour_v   = vals[3*CW +: CW];
  assign low_full = (sub_v == CW'(127)) && (sec_v == CW'(59)) && (min_v == CW'(59));
  assign full_now = low_full && (hour_mode ? (hour_v >= CW'(23)) : (hour_v == CW'(255)));

  p_sub_wrap_r1: assert property (@(posedge clk) disable iff (por || warm_rst)
    (tick && !wr_en && sub_v == CW'(127)) |=> (sub_v == '0));

  p_sec_carry_r2: assert property (@(posedge clk) disable iff (por || warm_rst)
    (tick && !wr_en && sub_v == CW'(127) && sec_v == CW'(59)) |=> (sec_v == '0 && sub_v == '0));

  p_hour24_r3: assert property (@(posedge clk) disable iff (por || warm_rst)
    (tick && !wr_en && hour_mode && low_full && hour_v == CW'(23)) |=> (hour_v == '0));

  p_midnight_set_r4: assert property (@(posedge clk) disable iff (por || warm_rst)
    (tick && full_now) |=> irq);

  p_warm_keep_r6: assert property (@(posedge clk) disable iff (por)
    (warm_rst && !wr_en) |=> ($stable(vals) && $stable(hour_mode) && !irq));

  p_hold_r7: assert property (@(posedge clk) disable iff (por)
    (!rtc_en && !wr_en) |=> $stable(vals));

  p_wr_prio_r8: assert property (@(posedge clk) disable iff (por)
    (wr_en && addr == AW'(1)) |=> (sub_v == $past(wr_data)));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (por || warm_rst)
    (tick && full_now && wr_en && addr == AW'(0) && !wr_data[1]) |=> irq);
endmodule

bind rtc_chain rtc_chain_checker #(.CW(CW), .AW(AW)) u_chk (
  .clk       (clk),
  .por       (por),
  .warm_rst  (warm_rst),
  .rtc_en    (rtc_en),
  .wr_en     (wr_en),
  .addr      (addr),
  .wr_data   (wr_data),
  .tick      (tick),
  .hour_mode (hour_mode),
  .irq       (irq_midnight),
  .vals      (stage_val)
);

// File: tb/rtc_chain_test.sv
`timescale 1ns/1ps
module rtc_chain_test;
  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       warm_rst = 1'b0;
  logic       rtc_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq_midnight;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_chain uut (
    .clk          (clk),
    .por          (por),
    .warm_rst     (warm_rst),
    .rtc_en       (rtc_en),
    .wr_en        (wr_en),
    .addr         (addr),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .irq_midnight (irq_midnight)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic run_en(input int n);
    @(negedge clk);
    rtc_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    rtc_en = 1'b0;
  endtask

  task automatic warm();
    @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m,
                          input logic [7:0] s, input logic [7:0] f);
    wr(3'd4, h); wr(3'd3, m); wr(3'd2, s); wr(3'd1, f);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R6 por clears register", v, 8'd0);
    end
    check("R6 irq low after por", {7'd0, irq_midnight}, 8'd0);
    rd(3'd6, v);
    check("R10 unused address reads 0", v, 8'd0);
  endtask

  task automatic t_sub_step();
    logic [7:0] v;
    warm();
    run_en(255);
    rd(3'd1, v);
    check("R1 no step before 256 enabled cycles", v, 8'd0);
    run_en(1);
    rd(3'd1, v);
    check("R1 step after 256 enabled cycles", v, 8'd1);
    repeat (600) @(posedge clk);
    rd(3'd1, v);
    check("R7 hold while disabled", v, 8'd1);
  endtask

  task automatic t_sub_wrap();
    logic [7:0] v;
    warm();
    set_time(8'd0, 8'd0, 8'd5, 8'd127);
    run_en(256);
    rd(3'd1, v); check("R1 sub wraps to 0", v, 8'd0);
    rd(3'd2, v); check("R1 carry into seconds", v, 8'd6);
  endtask

  task automatic t_sec_min();
    logic [7:0] v;
    warm();
    wr(3'd0, 8'h01);
    set_time(8'd3, 8'd59, 8'd59, 8'd127);
    run_en(256);
    rd(3'd2, v); check("R2 seconds wrap", v, 8'd0);
    rd(3'd3, v); check("R2 minutes wrap", v, 8'd0);
    rd(3'd4, v); check("R2 carry into hours", v, 8'd4);
    check("R4 no flag without hour wrap", {7'd0, irq_midnight}, 8'd0);
  endtask

  task automatic t_midnight24();
    logic [7:0] v;
    warm();
    wr(3'd0, 8'h01);
    set_time(8'd23, 8'd59, 8'd59, 8'd127);
    run_en(256);
    rd(3'd4, v); check("R3 24h wrap to 0", v, 8'd0);
    rd(3'd0, v); check("R4 flag and mode set", v, 8'h03);
    check("R4 irq raised", {7'd0, irq_midnight}, 8'd1);
    wr(3'd0, 8'h03);
    rd(3'd0, v); check("R5 write 1 keeps flag", v, 8'h03);
    wr(3'd0, 8'h01);
    rd(3'd0, v); check("R5 write 0 clears flag", v, 8'h01);
    check("R5 irq dropped", {7'd0, irq_midnight}, 8'd0);
  endtask

  task automatic t_256h();
    logic [7:0] v;
    warm();
    wr(3'd0, 8'h00);
    set_time(8'd23, 8'd59, 8'd59, 8'd127);
    run_en(256);
    rd(3'd4, v); check("R3 256h passes 23", v, 8'd24);
    check("R3 no flag at 24 in 256h mode", {7'd0, irq_midnight}, 8'd0);
    set_time(8'd255, 8'd59, 8'd59, 8'd127);
    run_en(256);
    rd(3'd4, v); check("R3 256h wrap to 0", v, 8'd0);
    check("R4 flag in 256h mode", {7'd0, irq_midnight}, 8'd1);
  endtask

  task automatic t_warm_keep();
    logic [7:0] v;
    wr(3'd0, 8'h01);
    set_time(8'd7, 8'd8, 8'd9, 8'd10);
    warm();
    rd(3'd4, v); check("R6 warm keeps hours", v, 8'd7);
    rd(3'd3, v); check("R6 warm keeps minutes", v, 8'd8);
    rd(3'd2, v); check("R6 warm keeps seconds", v, 8'd9);
    rd(3'd1, v); check("R6 warm keeps sub", v, 8'd10);
    rd(3'd0, v); check("R6 warm keeps mode, clears flag", v, 8'h01);
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
    rd(3'd4, v); check("R6 por clears hours", v, 8'd0);
    rd(3'd0, v); check("R6 por clears mode", v, 8'd0);
  endtask

  task automatic t_write_prio();
    logic [7:0] v;
    warm();
    set_time(8'd0, 8'd0, 8'd0, 8'd10);
    @(negedge clk);
    rtc_en = 1'b1;
    repeat (255) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd1; wr_data = 8'd50;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rtc_en = 1'b0;
    rd(3'd1, v); check("R8 write beats increment", v, 8'd50);
    run_en(256);
    rd(3'd1, v); check("R8 counting resumes from written value", v, 8'd51);
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    warm();
    wr(3'd0, 8'h01);
    set_time(8'd23, 8'd59, 8'd59, 8'd127);
    @(negedge clk);
    rtc_en = 1'b1;
    repeat (255) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wr_data = 8'h01;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rtc_en = 1'b0;
    rd(3'd0, v); check("R9 set beats same-cycle clear", v, 8'h03);
    wr(3'd0, 8'h01);
    rd(3'd0, v); check("R9 later clear works", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    por = 1'b0;
    t_reset();
    t_sub_step();
    t_sub_wrap();
    t_sec_min();
    t_midnight24();
    t_256h();
    t_warm_keep();
    t_write_prio();
    t_set_wins();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule